// File: doc/BRIEF.md
# FIFO Fill-Level Threshold Flags

This block sits beside a dual-clock FIFO core and turns its occupancy counts into three active-low level flags: almost-empty, almost-full and half-full. It holds two programmable thresholds. The empty threshold `n` sets how close to empty the almost-empty flag warns. The full threshold `m` sets how close to full the almost-full flag warns. The core supplies a word count in the write-clock domain and another in the read-clock domain. This block does not cross them between domains.

The level of `load_i` while master reset is held does two things. It picks the starting value of both thresholds, and it fixes how software may change them afterwards. The thresholds can be written either bit-serially or a whole word per write-clock edge, but only by the method that reset chose. Either way, they can be read back one at a time on the read clock.

A partial reset restarts the access sequencing and clears the read-back register. It leaves the thresholds and the chosen method unchanged.

Top module: `fifo_level_flags`

## Requirements
- R1: With rst_ni low, `load_i` low selects word-wide programming and sets both thresholds to 127. `load_i` high selects serial programming and sets both thresholds to 1023. The choice takes effect when reset is released.
- R2: While and right after master reset, `ae_no` is 0, `af_no` is 1, `hf_no` is 1 and `rdata_o` is 0.
- R3: In word-wide mode, a write-clock edge with `wen_i` and `load_i` both high stores `wdata_i` into a threshold. The first such write after a reset goes to the empty threshold, the next to the full threshold, and they keep alternating.
- R4: In serial mode, a write-clock edge with `sen_i` and `load_i` both high shifts `si_i` in, least significant bit first. The first OFS_W bits fill the empty threshold, the next OFS_W bits fill the full threshold, and the sequence then starts over.
- R5: A load attempted with the method that reset did not select leaves both thresholds unchanged.
- R6: A read-clock edge with `ren_i` and `load_i` both high places a threshold on `rdata_o` after that edge. The empty threshold comes first, then the full threshold, alternating. On other read-clock edges `rdata_o` holds its value. Read-back works in either mode.
- R7: `ae_no` is 0 exactly when `rcnt_i` is less than `n`. It is updated on each read-clock edge.
- R8: `af_no` is 0 exactly when `wcnt_i` is greater than DEPTH − `m`. It is updated on each write-clock edge.
- R9: `hf_no` is 0 exactly when `wcnt_i` is greater than DEPTH/2. It is updated on each write-clock edge.
- R10: A write-clock and read-clock edge with `part_rst_i` high restarts both alternations and the serial bit position, and clears `rdata_o`. The thresholds and the programming mode are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk_i | input | 1 | Write-side clock |
| rclk_i | input | 1 | Read-side clock |
| rst_ni | input | 1 | Master reset, asynchronous, active low |
| part_rst_i | input | 1 | Partial reset, synchronous to both clocks, active high |
| load_i | input | 1 | Mode select during reset; threshold access strobe afterwards |
| wen_i | input | 1 | Word-wide threshold write enable |
| sen_i | input | 1 | Serial threshold shift enable |
| si_i | input | 1 | Serial threshold data bit |
| wdata_i | input | OFS_W | Word-wide threshold value |
| ren_i | input | 1 | Threshold read-back enable |
| wcnt_i | input | CNT_W | Occupancy seen in the write domain (0..DEPTH) |
| rcnt_i | input | CNT_W | Occupancy seen in the read domain (0..DEPTH) |
| rdata_o | output | OFS_W | Read-back threshold value |
| ae_no | output | 1 | Almost-empty, active low |
| af_no | output | 1 | Almost-full, active low |
| hf_no | output | 1 | Half-full, active low |

## Verification
Every result here comes from exactly one clock edge of its own domain. A threshold write becomes visible at the first read-back edge after it. Read-back data appears one read-clock edge after the strobe. Each flag reflects the count sampled at the latest edge of its own clock. The bench changes inputs on falling edges and samples on the next falling edge, so exactly one rising edge of each clock lies between stimulus and check. The flag sweeps step both counts through every value from 0 to DEPTH once per cycle, with several threshold pairs, including thresholds of zero and the largest value.

// File: rtl/thr_pkg.sv
package thr_pkg;
  typedef enum logic {PGM_WORD = 1'b0, PGM_SER = 1'b1} pgm_mode_e;
  typedef enum logic {SEL_EMPTY = 1'b0, SEL_FULL = 1'b1} thr_sel_e;
endpackage

// File: rtl/thr_flag_reg.sv
module thr_flag_reg #(
  parameter int unsigned CNT_W   = 12,
  parameter bit          GT      = 1'b1,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             flag_no
);
  logic hit;

  generate
    if (GT) begin : g_gt
      assign hit = cnt_i > lim_i;
      assert_zero_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_i == '0) |=> flag_no);
    end else begin : g_lt
      assign hit = cnt_i < lim_i;
      assert_zero_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_i == '0 && lim_i != '0) |=> !flag_no);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_no <= RST_VAL;
    else         flag_no <= ~hit;
  end
endmodule

// File: rtl/thr_ofs_bank.sv
module thr_ofs_bank
  import thr_pkg::*;
#(
  parameter int unsigned OFS_W  = 11,
  parameter int unsigned DEF_LO = 127,
  parameter int unsigned DEF_HI = 1023
) (
  input  logic             wclk_i,
  input  logic             rst_ni,
  input  logic             part_rst_i,
  input  logic             load_i,
  input  logic             wen_i,
  input  logic             sen_i,
  input  logic             si_i,
  input  logic [OFS_W-1:0] wdata_i,
  output logic [OFS_W-1:0] ofs_e_o,
  output logic [OFS_W-1:0] ofs_f_o
);
  localparam int unsigned SB_W = $clog2(2 * OFS_W);
  localparam logic [SB_W-1:0] SB_LAST = SB_W'(2 * OFS_W - 1);
  localparam logic [SB_W-1:0] SB_HALF = SB_W'(OFS_W);
  localparam logic [OFS_W-1:0] V_LO = OFS_W'(DEF_LO);
  localparam logic [OFS_W-1:0] V_HI = OFS_W'(DEF_HI);

  pgm_mode_e        mode_q;
  thr_sel_e         wsel_q;
  logic [SB_W-1:0]  sbit_q;
  logic [OFS_W-1:0] ofs_e_q, ofs_f_q;
  logic             word_we, ser_we, ser_full;

  assign word_we  = (mode_q == PGM_WORD) && wen_i && load_i && !part_rst_i;
  assign ser_we   = (mode_q == PGM_SER) && sen_i && load_i && !part_rst_i;
  assign ser_full = sbit_q >= SB_HALF;

  // reset level of load_i fixes mode and default thresholds
  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= load_i ? PGM_SER : PGM_WORD;
      ofs_e_q <= load_i ? V_HI : V_LO;
      ofs_f_q <= load_i ? V_HI : V_LO;
      wsel_q  <= SEL_EMPTY;
      sbit_q  <= '0;
    end else if (part_rst_i) begin
      wsel_q  <= SEL_EMPTY;
      sbit_q  <= '0;
    end else if (word_we) begin
      if (wsel_q == SEL_EMPTY) ofs_e_q <= wdata_i;
      else                     ofs_f_q <= wdata_i;
      wsel_q <= (wsel_q == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
    end else if (ser_we) begin
      if (!ser_full) ofs_e_q <= {si_i, ofs_e_q[OFS_W-1:1]};
      else           ofs_f_q <= {si_i, ofs_f_q[OFS_W-1:1]};
      sbit_q <= (sbit_q == SB_LAST) ? '0 : sbit_q + 1'b1;
    end
  end

  assign ofs_e_o = ofs_e_q;
  assign ofs_f_o = ofs_f_q;

  assert_word_ignored_R5: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (mode_q == PGM_SER && wen_i && load_i && !sen_i) |=> ($stable(ofs_e_q) && $stable(ofs_f_q)));
  assert_ser_ignored_R5: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (mode_q == PGM_WORD && sen_i && load_i && !wen_i) |=> ($stable(ofs_e_q) && $stable(ofs_f_q)));
  assert_sbit_bound_R4: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    sbit_q <= SB_LAST);
  assert_prst_keep_R10: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    part_rst_i |=> ($stable(ofs_e_q) && $stable(ofs_f_q) && sbit_q == '0));
endmodule

// File: rtl/thr_readback.sv
module thr_readback
  import thr_pkg::*;
#(
  parameter int unsigned OFS_W = 11
) (
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic             part_rst_i,
  input  logic             ren_i,
  input  logic             load_i,
  input  logic [OFS_W-1:0] ofs_e_i,
  input  logic [OFS_W-1:0] ofs_f_i,
  output logic [OFS_W-1:0] rdata_o
);
  thr_sel_e rsel_q;

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsel_q  <= SEL_EMPTY;
      rdata_o <= '0;
    end else if (part_rst_i) begin
      rsel_q  <= SEL_EMPTY;
      rdata_o <= '0;
    end else if (ren_i && load_i) begin
      rdata_o <= (rsel_q == SEL_EMPTY) ? ofs_e_i : ofs_f_i;
      rsel_q  <= (rsel_q == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
    end
  end

  assert_rdata_hold_R6: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!(ren_i && load_i) && !part_rst_i) |=> $stable(rdata_o));
  assert_prst_clear_R10: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    part_rst_i |=> (rdata_o == '0));
endmodule

// File: rtl/fifo_level_flags.sv
module fifo_level_flags #(
  parameter int unsigned DEPTH  = 2048,
  parameter int unsigned DEF_LO = 127,
  parameter int unsigned DEF_HI = 1023,
  localparam int unsigned OFS_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             wclk_i,
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic             part_rst_i,
  input  logic             load_i,
  input  logic             wen_i,
  input  logic             sen_i,
  input  logic             si_i,
  input  logic [OFS_W-1:0] wdata_i,
  input  logic             ren_i,
  input  logic [CNT_W-1:0] wcnt_i,
  input  logic [CNT_W-1:0] rcnt_i,
  output logic [OFS_W-1:0] rdata_o,
  output logic             ae_no,
  output logic             af_no,
  output logic             hf_no
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

  logic [OFS_W-1:0] ofs_e, ofs_f;
  logic [CNT_W-1:0] af_lim, ae_lim;

  assign af_lim = FULL_CNT - CNT_W'(ofs_f);
  assign ae_lim = CNT_W'(ofs_e);

  thr_ofs_bank #(.OFS_W(OFS_W), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)) u_bank (
    .wclk_i, .rst_ni, .part_rst_i, .load_i, .wen_i, .sen_i, .si_i, .wdata_i,
    .ofs_e_o(ofs_e), .ofs_f_o(ofs_f)
  );

  // thresholds are quasi-static when read from the read domain
  thr_readback #(.OFS_W(OFS_W)) u_rb (
    .rclk_i, .rst_ni, .part_rst_i, .ren_i, .load_i,
    .ofs_e_i(ofs_e), .ofs_f_i(ofs_f), .rdata_o
  );

  thr_flag_reg #(.CNT_W(CNT_W), .GT(1'b1), .RST_VAL(1'b1)) u_af (
    .clk_i(wclk_i), .rst_ni, .cnt_i(wcnt_i), .lim_i(af_lim), .flag_no(af_no)
  );

  thr_flag_reg #(.CNT_W(CNT_W), .GT(1'b1), .RST_VAL(1'b1)) u_hf (
    .clk_i(wclk_i), .rst_ni, .cnt_i(wcnt_i), .lim_i(HALF_CNT), .flag_no(hf_no)
  );

  thr_flag_reg #(.CNT_W(CNT_W), .GT(1'b0), .RST_VAL(1'b0)) u_ae (
    .clk_i(rclk_i), .rst_ni, .cnt_i(rcnt_i), .lim_i(ae_lim), .flag_no(ae_no)
  );

  assert_full_hf_R9: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wcnt_i == FULL_CNT) |=> !hf_no);
  assert_empty_hf_R9: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wcnt_i == '0) |=> (hf_no && af_no));
endmodule

// File: tb/fifo_level_flags_test.sv
`timescale 1ns/100ps
module fifo_level_flags_test;
  localparam int DEPTH = 2048;
  localparam int OFS_W = 11;
  localparam int CNT_W = 12;

  logic wclk = 0, rclk = 0;
  logic rst_ni = 0, part_rst = 0, load = 0, wen = 0, sen = 0, si = 0, ren = 0;
  logic [OFS_W-1:0] wdata = '0;
  logic [CNT_W-1:0] wcnt = '0, rcnt = '0;
  logic [OFS_W-1:0] rdata;
  logic ae_no, af_no, hf_no;
  int vectors = 0, miscompares = 0;
  int exp_e, exp_f;

  always #2 wclk = ~wclk;
  initial begin #1; forever #2 rclk = ~rclk; end

  fifo_level_flags uut (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_ni), .part_rst_i(part_rst),
    .load_i(load), .wen_i(wen), .sen_i(sen), .si_i(si), .wdata_i(wdata),
    .ren_i(ren), .wcnt_i(wcnt), .rcnt_i(rcnt), .rdata_o(rdata),
    .ae_no(ae_no), .af_no(af_no), .hf_no(hf_no)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic mreset(input logic lvl);
    @(negedge wclk);
    rst_ni = 0; load = lvl; wcnt = '0; rcnt = '0;
    repeat (3) @(negedge wclk);
    rst_ni = 1; load = 0;
    exp_e = lvl ? 1023 : 127;
    exp_f = exp_e;
  endtask

  task automatic word_wr(input int v);
    @(negedge wclk);
    wen = 1; load = 1; wdata = OFS_W'(v);
    @(negedge wclk);
    wen = 0; load = 0;
  endtask

  task automatic ser_wr(input int e, input int f, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      @(negedge wclk);
      sen = 1; load = 1;
      si = (i < OFS_W) ? e[i] : f[i - OFS_W];
    end
    @(negedge wclk);
    sen = 0; load = 0; si = 0;
  endtask

  task automatic rd_one(input string req, input int exp);
    @(negedge rclk);
    ren = 1; load = 1;
    @(negedge rclk);
    ren = 0; load = 0;
    check(req, int'(rdata), exp);
  endtask

  task automatic rd_pair(input string req);
    rd_one(req, exp_e);
    rd_one(req, exp_f);
  endtask

  task automatic prst;
    @(negedge wclk);
    part_rst = 1;
    repeat (2) @(negedge wclk);
    part_rst = 0;
  endtask

  // R7 R8 R9: every count 0..DEPTH, flags due one edge later
  task automatic sweep;
    for (int c = 0; c <= DEPTH; c++) begin
      @(negedge wclk);
      wcnt = CNT_W'(c);
      rcnt = CNT_W'(DEPTH - c);
      @(negedge wclk);
      check("R8 af", int'(af_no), (c > DEPTH - exp_f) ? 0 : 1);
      check("R9 hf", int'(hf_no), (c > DEPTH / 2) ? 0 : 1);
      check("R7 ae", int'(ae_no), ((DEPTH - c) < exp_e) ? 0 : 1);
    end
    @(negedge wclk);
    wcnt = '0; rcnt = '0;
  endtask

  initial begin
    #700000;
    miscompares++;
    $display("FAIL watchdog act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    mreset(1'b0);
    check("R2 ae", int'(ae_no), 0);
    check("R2 af", int'(af_no), 1);
    check("R2 hf", int'(hf_no), 1);
    check("R2 rdata", int'(rdata), 0);
    rd_pair("R1 word defaults");
    sweep();

    word_wr(300); word_wr(5);
    exp_e = 300; exp_f = 5;
    rd_pair("R3 word load");
    ser_wr(1, 2, 2 * OFS_W);
    rd_pair("R5 serial in word mode");
    @(negedge rclk); ren = 1; load = 0;
    @(negedge rclk); ren = 0;
    check("R6 hold without load", int'(rdata), 5);
    sweep();

    word_wr(0); word_wr(2047);
    exp_e = 0; exp_f = 2047;
    rd_pair("R3 extremes");
    sweep();

    word_wr(11);
    exp_e = 11;
    rd_one("R6 first after pair", 11);
    prst();
    check("R10 rdata cleared", int'(rdata), 0);
    word_wr(22);
    exp_e = 22;
    rd_pair("R10 pointers restart");

    mreset(1'b1);
    check("R2 rdata serial", int'(rdata), 0);
    rd_pair("R1 serial defaults");
    sweep();
    ser_wr(77, 1500, 2 * OFS_W);
    exp_e = 77; exp_f = 1500;
    rd_pair("R4 serial load");
    word_wr(9);
    rd_pair("R5 word in serial mode");
    ser_wr(3, 0, 5);
    prst();
    ser_wr(1, 2, 2 * OFS_W);
    exp_e = 1; exp_f = 2;
    rd_pair("R10 serial index restart");
    word_wr(9);
    rd_pair("R10 mode kept");
    ser_wr(400, 600, 2 * OFS_W);
    exp_e = 400; exp_f = 600;
    rd_pair("R4 serial reload");
    sweep();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule